// File: doc/BRIEF.md
# Bit-Addressable Scratchpad RAM with Stack

This block is the 128-byte internal data memory of a small 8-bit controller core. The array can be reached in four ways, each on its own port: plain byte access, single-bit access into a 16-byte bit-addressable region, working-register access through a selectable bank of eight bytes, and a stack driven by an internal 8-bit stack pointer. The stack pointer is also exposed as a readable and writable special-function value.

All reads are combinational from the addressed location. All writes take effect at the rising clock edge. Several ports may write in the same cycle. Writes to different bytes all land. When two writes hit the same byte, a fixed priority decides which one wins. A bit write is a read-modify-write of the byte that holds the bit, and it completes in one cycle.

Top module: `iram_scratchpad`

## Requirements
- R1: After reset, the stack pointer reads 07h and every byte of the array reads 00h.
- R2: A byte-port write stores `byteWrData` at `byteAddr` (00h–7Fh) at the clock edge. `byteRdData` then shows the stored byte for any address.
- R3: A read in the same cycle as a write to the same byte returns the byte's old value.
- R4: A register-port access with bank `regBank` = k and index `regIdx` = n reaches byte address k*8 + n. This holds for both reads and writes.
- R5: Bit address b (00h–7Fh) selects bit (b mod 8) of byte 20h + (b div 8). `bitRdVal` shows that bit.
- R6: `bitOp` encodes the bit operation: 0 does nothing, 1 sets the bit, 2 clears it, and 3 loads `bitWrVal`. The other seven bits of the byte keep their values.
- R7: A push first increments the stack pointer and then writes `pushData` at the new pointer, so the first push after reset lands at 08h.
- R8: `popData` shows the byte at the current stack pointer, and a pop decrements the pointer at the edge. When push and pop are both requested, only the push takes place.
- R9: The stack pointer wraps modulo 256. A push whose new pointer is 80h or above writes nothing and raises `pushDropped` in that cycle. `popData` reads 00h while the pointer is 80h or above.
- R10: A stack-pointer write loads `spWrData` at the edge when there is no push or pop. A push or pop in the same cycle takes precedence over it.
- R11: When several writes hit the same byte in one cycle, the priority is push first, then register port, then byte port, then bit port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| byteAddr | input | 7 | Byte-port address |
| byteWrEn | input | 1 | Byte-port write enable |
| byteWrData | input | 8 | Byte-port write data |
| byteRdData | output | 8 | Byte at `byteAddr` |
| regBank | input | 2 | Register bank select |
| regIdx | input | 3 | Register index within the bank |
| regWrEn | input | 1 | Register-port write enable |
| regWrData | input | 8 | Register-port write data |
| regRdData | output | 8 | Selected register value |
| bitAddr | input | 7 | Bit address |
| bitOp | input | 2 | Bit operation: 0 none, 1 set, 2 clear, 3 load |
| bitWrVal | input | 1 | Value stored by the load operation |
| bitRdVal | output | 1 | Addressed bit |
| pushEn | input | 1 | Push strobe |
| pushData | input | 8 | Byte to push |
| popEn | input | 1 | Pop strobe |
| popData | output | 8 | Byte at the stack pointer |
| spWrEn | input | 1 | Stack-pointer write enable |
| spWrData | input | 8 | New stack-pointer value |
| spVal | output | 8 | Current stack pointer |
| pushDropped | output | 1 | Current push targets an address outside the array |

## Verification
Write collisions are the main risk in this block. The bench drives two ports in the same cycle at the same byte and checks that the winner follows the fixed priority: a bit set together with a byte write, a register write together with a byte write, and a push together with a register write. It also drives two ports at different bytes in one cycle and confirms that both writes land. Push and pop are requested together, and so are a stack-pointer write and a push. The expected pointer and memory contents come from a shadow array kept in the bench.

// File: rtl/iram_pkg.sv
package iram_pkg;
  localparam int DEPTH    = 128;
  localparam int AW       = $clog2(DEPTH);
  localparam int DW       = 8;
  localparam int SPW      = 8;
  localparam int BANKW    = 2;
  localparam int REGW     = 3;
  localparam int BITPOSW  = $clog2(DW);
  localparam int BAW      = 7;
  localparam logic [AW-1:0]  BIT_BASE = AW'(8'h20);
  localparam logic [SPW-1:0] SP_RESET = 8'h07;

  typedef enum logic [1:0] {
    BIT_NONE = 2'd0,
    BIT_SET  = 2'd1,
    BIT_CLR  = 2'd2,
    BIT_LOAD = 2'd3
  } bitOp_e;

  typedef struct packed {
    logic               pushWe;
    logic [AW-1:0]      pushAddr;
    logic               regWe;
    logic [AW-1:0]      regAddr;
    logic               byteWe;
    logic [AW-1:0]      byteAddr;
    logic               bitWe;
    logic [AW-1:0]      bitByte;
    logic [BITPOSW-1:0] bitPos;
    logic               bitVal;
    logic               spInRange;
    logic [AW-1:0]      spAddr;
  } memCtl_t;
endpackage

// File: rtl/iram_ctrl.sv
module iram_ctrl
  import iram_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [AW-1:0]    byteAddr,
  input  logic             byteWrEn,
  input  logic [BANKW-1:0] regBank,
  input  logic [REGW-1:0]  regIdx,
  input  logic             regWrEn,
  input  logic [BAW-1:0]   bitAddr,
  input  logic [1:0]       bitOp,
  input  logic             bitWrVal,
  input  logic             pushEn,
  input  logic             popEn,
  input  logic             spWrEn,
  input  logic [SPW-1:0]   spWrData,
  output memCtl_t          ctl,
  output logic [SPW-1:0]   spVal,
  output logic             pushDropped
);
  logic [SPW-1:0] spInc;
  logic           incInRange;
  bitOp_e         opKind;

  assign spInc      = spVal + 1'b1;
  assign incInRange = (spInc[SPW-1:AW] == '0);
  assign opKind     = bitOp_e'(bitOp);

  // Stack pointer: push beats pop, both beat an SFR write
  always_ff @(posedge clk) begin
    if (!rstN)       spVal <= SP_RESET;
    else if (pushEn) spVal <= spInc;
    else if (popEn)  spVal <= spVal - 1'b1;
    else if (spWrEn) spVal <= spWrData;
  end

  always_comb begin
    ctl           = '0;
    ctl.pushWe    = pushEn && incInRange;
    ctl.pushAddr  = spInc[AW-1:0];
    ctl.regWe     = regWrEn;
    ctl.regAddr   = AW'({regBank, regIdx});
    ctl.byteWe    = byteWrEn;
    ctl.byteAddr  = byteAddr;
    ctl.bitWe     = (opKind != BIT_NONE);
    ctl.bitByte   = BIT_BASE + AW'(bitAddr[BAW-1:BITPOSW]);
    ctl.bitPos    = bitAddr[BITPOSW-1:0];
    ctl.spInRange = (spVal[SPW-1:AW] == '0);
    ctl.spAddr    = spVal[AW-1:0];
    unique case (opKind)
      BIT_SET:  ctl.bitVal = 1'b1;
      BIT_CLR:  ctl.bitVal = 1'b0;
      BIT_LOAD: ctl.bitVal = bitWrVal;
      default:  ctl.bitVal = 1'b0;
    endcase
    pushDropped = pushEn && !incInRange;
  end
endmodule

// File: rtl/iram_data.sv
module iram_data
  import iram_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  memCtl_t       ctl,
  input  logic [DW-1:0] byteWrData,
  input  logic [DW-1:0] regWrData,
  input  logic [DW-1:0] pushData,
  output logic [DW-1:0] byteRdData,
  output logic [DW-1:0] regRdData,
  output logic          bitRdVal,
  output logic [DW-1:0] popData
);
  logic [DW-1:0] memQ [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic [DW-1:0] cellQ;
    logic [DW-1:0] cellNext;
    logic          cellHit;

    // Lowest priority applied first so that later writes override it
    always_comb begin
      cellNext = cellQ;
      cellHit  = 1'b0;
      if (ctl.bitWe && ctl.bitByte == AW'(i)) begin
        cellNext[ctl.bitPos] = ctl.bitVal;
        cellHit = 1'b1;
      end
      if (ctl.byteWe && ctl.byteAddr == AW'(i)) begin
        cellNext = byteWrData;
        cellHit  = 1'b1;
      end
      if (ctl.regWe && ctl.regAddr == AW'(i)) begin
        cellNext = regWrData;
        cellHit  = 1'b1;
      end
      if (ctl.pushWe && ctl.pushAddr == AW'(i)) begin
        cellNext = pushData;
        cellHit  = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)        cellQ <= '0;
      else if (cellHit) cellQ <= cellNext;
    end

    assign memQ[i] = cellQ;
  end

  assign byteRdData = memQ[ctl.byteAddr];
  assign regRdData  = memQ[ctl.regAddr];
  assign bitRdVal   = memQ[ctl.bitByte][ctl.bitPos];
  assign popData    = ctl.spInRange ? memQ[ctl.spAddr] : '0;
endmodule

// File: rtl/iram_scratchpad.sv
module iram_scratchpad
  import iram_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [AW-1:0]    byteAddr,
  input  logic             byteWrEn,
  input  logic [DW-1:0]    byteWrData,
  output logic [DW-1:0]    byteRdData,
  input  logic [BANKW-1:0] regBank,
  input  logic [REGW-1:0]  regIdx,
  input  logic             regWrEn,
  input  logic [DW-1:0]    regWrData,
  output logic [DW-1:0]    regRdData,
  input  logic [BAW-1:0]   bitAddr,
  input  logic [1:0]       bitOp,
  input  logic             bitWrVal,
  output logic             bitRdVal,
  input  logic             pushEn,
  input  logic [DW-1:0]    pushData,
  input  logic             popEn,
  output logic [DW-1:0]    popData,
  input  logic             spWrEn,
  input  logic [SPW-1:0]   spWrData,
  output logic [SPW-1:0]   spVal,
  output logic             pushDropped
);
  memCtl_t ctl;

  iram_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .byteAddr(byteAddr), .byteWrEn(byteWrEn),
    .regBank(regBank), .regIdx(regIdx), .regWrEn(regWrEn),
    .bitAddr(bitAddr), .bitOp(bitOp), .bitWrVal(bitWrVal),
    .pushEn(pushEn), .popEn(popEn),
    .spWrEn(spWrEn), .spWrData(spWrData),
    .ctl(ctl), .spVal(spVal), .pushDropped(pushDropped)
  );

  iram_data data_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .byteWrData(byteWrData), .regWrData(regWrData), .pushData(pushData),
    .byteRdData(byteRdData), .regRdData(regRdData),
    .bitRdVal(bitRdVal), .popData(popData)
  );
endmodule

// File: rtl/iram_scratchpad_chk.sv
module iram_scratchpad_chk
  import iram_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [AW-1:0]    byteAddr,
  input logic             byteWrEn,
  input logic [DW-1:0]    byteWrData,
  input logic [DW-1:0]    byteRdData,
  input logic             regWrEn,
  input logic [BAW-1:0]   bitAddr,
  input logic [1:0]       bitOp,
  input logic             bitRdVal,
  input logic             pushEn,
  input logic             popEn,
  input logic [DW-1:0]    popData,
  input logic             spWrEn,
  input logic [SPW-1:0]   spWrData,
  input logic [SPW-1:0]   spVal,
  input logic             pushDropped
);
  a_r2_byte_store: assert property (@(posedge clk) disable iff (!rstN)
    (byteWrEn && !pushEn && !regWrEn && bitOp == 2'd0)
    |=> (byteAddr != $past(byteAddr)) || (byteRdData == $past(byteWrData)));

  a_r6_bit_set: assert property (@(posedge clk) disable iff (!rstN)
    (bitOp == 2'd1 && !pushEn && !regWrEn && !byteWrEn)
    |=> (bitAddr != $past(bitAddr)) || bitRdVal);

  a_r6_bit_clear: assert property (@(posedge clk) disable iff (!rstN)
    (bitOp == 2'd2 && !pushEn && !regWrEn && !byteWrEn)
    |=> (bitAddr != $past(bitAddr)) || !bitRdVal);

  a_r7_push_inc: assert property (@(posedge clk) disable iff (!rstN)
    pushEn |=> spVal == $past(spVal) + 8'd1);

  a_r8_pop_dec: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && !pushEn) |=> spVal == $past(spVal) - 8'd1);

  a_r9_pop_outside: assert property (@(posedge clk) disable iff (!rstN)
    spVal[SPW-1] |-> popData == '0);

  a_r9_drop_flag: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && spVal == 8'h7F) |-> pushDropped);

  a_r10_sp_load: assert property (@(posedge clk) disable iff (!rstN)
    (spWrEn && !pushEn && !popEn) |=> spVal == $past(spWrData));
endmodule

bind iram_scratchpad iram_scratchpad_chk chk_i (.*);

// File: tb/iram_scratchpad_tb_top.sv
module iram_scratchpad_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic [6:0] byteAddr;
  logic       byteWrEn;
  logic [7:0] byteWrData, byteRdData;
  logic [1:0] regBank;
  logic [2:0] regIdx;
  logic       regWrEn;
  logic [7:0] regWrData, regRdData;
  logic [6:0] bitAddr;
  logic [1:0] bitOp;
  logic       bitWrVal, bitRdVal;
  logic       pushEn, popEn, spWrEn, pushDropped;
  logic [7:0] pushData, popData, spWrData, spVal;

  logic [7:0] model [128];
  logic [7:0] sp;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iram_scratchpad dut_i (.*);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    byteWrEn = 0; regWrEn = 0; bitOp = 2'd0; pushEn = 0; popEn = 0; spWrEn = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle();
    #1;
  endtask

  task automatic chkAll(string req);
    for (int a = 0; a < 128; a++) begin
      byteAddr = 7'(a);
      #1;
      chk(req, byteRdData, model[a]);
    end
  endtask

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  initial begin
    idle();
    rstN = 0; byteAddr = 0; byteWrData = 0; regBank = 0; regIdx = 0;
    regWrData = 0; bitAddr = 0; bitWrVal = 0; pushData = 0; spWrData = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R1 reset state
    for (int a = 0; a < 128; a++) model[a] = 8'h00;
    sp = 8'h07;
    chk("R1 sp", spVal, 8'h07);
    chkAll("R1 mem");

    // R2 write every byte, read back
    for (int a = 0; a < 128; a++) begin
      byteAddr = 7'(a); byteWrData = pat(a); byteWrEn = 1;
      tick();
      model[a] = pat(a);
    end
    chkAll("R2");

    // R3 read during write of the same byte sees old value
    byteAddr = 7'h05; byteWrData = 8'hC3; byteWrEn = 1; #1;
    chk("R3", byteRdData, model[5]);
    tick(); model[5] = 8'hC3;
    chk("R2", byteRdData, 8'hC3);

    // R4 register port reads and writes
    for (int k = 0; k < 4; k++)
      for (int n = 0; n < 8; n++) begin
        regBank = 2'(k); regIdx = 3'(n); #1;
        chk("R4 read", regRdData, model[k*8+n]);
      end
    for (int k = 0; k < 4; k++) begin
      regBank = 2'(k); regIdx = 3'(k + 2); regWrData = 8'(8'h90 + k); regWrEn = 1;
      tick();
      model[k*8+k+2] = 8'(8'h90 + k);
      byteAddr = 7'(k*8+k+2); #1;
      chk("R4 write", byteRdData, model[k*8+k+2]);
    end

    // R5 every bit address
    for (int b = 0; b < 128; b++) begin
      bitAddr = 7'(b); #1;
      chk("R5", bitRdVal, model[32 + b/8][b%8]);
    end

    // R6 set / clear / load / none
    for (int b = 0; b < 128; b += 9) begin
      bitAddr = 7'(b); byteAddr = 7'(32 + b/8);
      bitOp = 2'd1; tick(); model[32+b/8][b%8] = 1'b1;
      chk("R6 set", byteRdData, model[32+b/8]);
      bitOp = 2'd2; tick(); model[32+b/8][b%8] = 1'b0;
      chk("R6 clear", byteRdData, model[32+b/8]);
      bitOp = 2'd3; bitWrVal = b[0]; tick(); model[32+b/8][b%8] = b[0];
      chk("R6 load", byteRdData, model[32+b/8]);
      bitOp = 2'd0; bitWrVal = ~b[0]; tick();
      chk("R6 none", byteRdData, model[32+b/8]);
    end

    // R7 pushes from reset pointer
    for (int i = 0; i < 3; i++) begin
      pushData = 8'(8'hA1 + i); pushEn = 1;
      tick();
      sp = sp + 1; model[sp] = 8'(8'hA1 + i);
      chk("R7 sp", spVal, sp);
    end
    byteAddr = 7'h08; #1;
    chk("R7 first slot", byteRdData, 8'hA1);

    // R8 pop
    chk("R8 top", popData, model[sp]);
    popEn = 1; #1;
    chk("R8 data", popData, 8'hA3);
    tick(); sp = sp - 1;
    chk("R8 sp", spVal, sp);
    chk("R8 next", popData, model[sp]);
    pushEn = 1; popEn = 1; pushData = 8'h5A;
    tick(); sp = sp + 1; model[sp] = 8'h5A;
    chk("R8 push wins sp", spVal, sp);
    chk("R8 push wins data", popData, 8'h5A);

    // R10 pointer load, and push over load
    spWrEn = 1; spWrData = 8'h40; tick(); sp = 8'h40;
    chk("R10 load", spVal, 8'h40);
    spWrEn = 1; spWrData = 8'h10; pushEn = 1; pushData = 8'h77;
    tick(); sp = 8'h41; model[8'h41] = 8'h77;
    chk("R10 push over load", spVal, 8'h41);
    spWrEn = 1; spWrData = 8'h10; popEn = 1;
    tick(); sp = 8'h40;
    chk("R10 pop over load", spVal, 8'h40);

    // R9 push off the top of the array
    spWrEn = 1; spWrData = 8'h7F; tick(); sp = 8'h7F;
    pushEn = 1; pushData = 8'hEE; #1;
    chk("R9 dropped flag", pushDropped, 1);
    tick(); sp = 8'h80;
    chk("R9 sp 80", spVal, 8'h80);
    chk("R9 pop outside", popData, 8'h00);
    chk("R9 flag clear", pushDropped, 0);
    chkAll("R9 nothing written");
    spWrEn = 1; spWrData = 8'hFF; tick();
    pushEn = 1; pushData = 8'h3C; #1;
    chk("R9 wrap no drop", pushDropped, 0);
    tick(); sp = 8'h00; model[0] = 8'h3C;
    chk("R9 wrap sp", spVal, 8'h00);
    byteAddr = 7'h00; #1;
    chk("R9 wrap write", byteRdData, 8'h3C);
    popEn = 1; tick();
    chk("R9 pop wrap", spVal, 8'hFF);

    // R11 same-byte priority
    byteAddr = 7'h21; byteWrData = 8'h00; byteWrEn = 1; bitAddr = 7'd8; bitOp = 2'd1;
    tick(); model[8'h21] = 8'h00;
    chk("R11 byte over bit", byteRdData, 8'h00);
    regBank = 2'd3; regIdx = 3'd2; regWrData = 8'h66; regWrEn = 1;
    byteAddr = 7'h1A; byteWrData = 8'h99; byteWrEn = 1;
    tick(); model[8'h1A] = 8'h66;
    chk("R11 reg over byte", byteRdData, 8'h66);
    spWrEn = 1; spWrData = 8'h0B; tick(); sp = 8'h0B;
    pushEn = 1; pushData = 8'h11; regBank = 2'd1; regIdx = 3'd4; regWrData = 8'h22; regWrEn = 1;
    tick(); sp = 8'h0C; model[8'h0C] = 8'h11;
    chk("R11 push over reg", regRdData, 8'h11);
    byteAddr = 7'h50; byteWrData = 8'hB4; byteWrEn = 1; bitAddr = 7'h7F; bitOp = 2'd3; bitWrVal = 1;
    tick(); model[8'h50] = 8'hB4; model[8'h2F][7] = 1'b1;
    chk("R11 separate bytes", byteRdData, 8'hB4);
    chk("R11 separate bit", bitRdVal, 1);
    chkAll("R11 final");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule